// File: doc/BRIEF.md
# Inductive Crosstalk Transition Checker

This block judges one transition of a five-pin bus segment against inductive-coupling limits. The segment has a supply pin at position 0, three signal pins at positions 1 to 3 and a ground pin at position 4. The block takes the word currently on the three signal pins and the word about to be driven. It reduces each signal pin's change to a three-valued code and tests every pin against its own coupling limit. It returns a vector with one bit per rule and a single flag that says whether the transition may be driven.

For each signal pin, the codes of the other two signal pins are multiplied by coupling weights and summed. A pin's immediate neighbour uses the near weight and the pin two places away uses the far weight. The limit that applies depends on what the pin itself does:
- A quiet pin needs the sum to stay inside an open window.
- A rising pin needs a sum that helps it upward.
- A falling pin needs a sum that helps it downward.

The supply pin limits how many signals rise together, and the ground pin limits how many fall together. All weights, the per-switch supply step and all limits are signed 8-bit run-time inputs. The block is purely combinational. An encoder can use it to screen candidate codewords, or it can be used offline to enumerate legal transitions.

Top module: `xt_transition_check`

## Requirements
- R1: Each signal bit is coded from its old value to its new value. 0 to 1 gives +1 (rising), 1 to 0 gives -1 (falling), and an unchanged bit gives 0 (quiet). Bit i of each word is signal pin i+1.
- R2: A quiet signal pin sets its quiet-rule bit unless its neighbour sum S satisfies -lim_static < S < lim_static. The bit is 0 whenever the pin is not quiet.
- R3: A rising signal pin sets its rise-rule bit unless S > lim_rise. The bit is 0 whenever the pin is not rising.
- R4: A falling signal pin sets its fall-rule bit unless S < lim_fall. The bit is 0 whenever the pin is not falling.
- R5: The neighbour sums are formed as follows:
  - pin 1: S = k_near·c2 + k_far·c3
  - pin 2: S = k_near·c1 + k_near·c3
  - pin 3: S = k_far·c1 + k_near·c2

  Here cN is the code of pin N.
- R6: The supply rule bit is set unless (z_step/2)·(number of rising signals) < lim_bounce. This is evaluated exactly as z_step·count < 2·lim_bounce.
- R7: The ground rule bit is set unless (z_step/2)·(number of falling signals) < lim_bounce, evaluated in the same exact way.
- R8: The viol bit order is fixed:
  - bit 0: supply rule
  - bits 1, 2, 3: rise, fall and quiet rules of pin 1
  - bits 4, 5, 6: the same three rules of pin 2
  - bits 7, 8, 9: the same three rules of pin 3
  - bit 10: ground rule
- R9: For each signal pin, at most one of its three rule bits is set.
- R10: legal is 1 exactly when all eleven viol bits are 0.
- R11: The results are exact for every input value, including -128 and 127, with no wrap-around in any sum, product or negation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prev_word | input | 3 | Signal pin values before the transition |
| next_word | input | 3 | Signal pin values after the transition |
| k_near | input | 8 | Signed coupling weight of an adjacent pin |
| k_far | input | 8 | Signed coupling weight of a pin two places away |
| z_step | input | 8 | Signed bounce contribution of one switching signal |
| lim_static | input | 8 | Signed half-width of the quiet-pin window |
| lim_rise | input | 8 | Signed lower limit for a rising pin |
| lim_fall | input | 8 | Signed upper limit for a falling pin |
| lim_bounce | input | 8 | Signed supply and ground bounce limit |
| viol | output | 11 | Per-rule violation bits in the R8 order |
| legal | output | 1 | High when no rule is violated |

## Verification
The supply rule and a signal pin's rise rule both react to the same rising edges, and the ground rule and a fall rule both react to the same falling edges. One transition can therefore trip a bounce limit and an edge limit together, or trip one and not the other. The bench provokes this with all-rising and all-falling words under chosen weights and limits. It also uses random words whose rising and falling counts vary. Every rule bit is judged on its own against a bench model, so a missed or mis-placed bit is caught even when legal would be 0 either way.

// File: rtl/xt_pkg.sv
package xt_pkg;

    // Segment geometry: one supply pin, signal pins, one ground pin.
    localparam int SEG_PINS      = 5;
    localparam int SIG_PINS      = SEG_PINS - 2;
    localparam int RULE_CNT      = 3 * SEG_PINS - 4;
    localparam int RULES_PER_SIG = 3;
    localparam int VDD_BIT       = 0;
    localparam int VSS_BIT       = RULE_CNT - 1;
    localparam int VAL_W         = 8;

    // Three-valued transition code held in two bits.
    typedef enum logic [1:0] {
        TR_STILL = 2'b00,
        TR_RISE  = 2'b01,
        TR_FALL  = 2'b11
    } trit_e;

    typedef struct packed {
        logic rise_bad;
        logic fall_bad;
        logic still_bad;
    } pin_viol_t;

    function automatic trit_e trit_of(input logic old_v, input logic new_v);
        if (old_v == new_v) return TR_STILL;
        return new_v ? TR_RISE : TR_FALL;
    endfunction

    // The lower- and higher-indexed partners of signal pin i among the three.
    function automatic int partner_lo(input int i);
        return (i == 0) ? 1 : 0;
    endfunction

    function automatic int partner_hi(input int i);
        return (i == SIG_PINS - 1) ? SIG_PINS - 2 : SIG_PINS - 1;
    endfunction

    function automatic int pin_dist(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

endpackage

// File: rtl/xt_trit_enc.sv
module xt_trit_enc
    import xt_pkg::*;
#(
    parameter int N = SIG_PINS
) (
    input  logic                [N-1:0] old_bits,
    input  logic                [N-1:0] new_bits,
    output xt_pkg::trit_e [N-1:0]       codes
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign codes[g] = trit_of(old_bits[g], new_bits[g]);
    end

endmodule

// File: rtl/xt_pin_rule.sv
module xt_pin_rule
    import xt_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  xt_pkg::trit_e       self_t,
    input  xt_pkg::trit_e       nb_a,
    input  xt_pkg::trit_e       nb_b,
    input  logic signed [W-1:0] w_a,
    input  logic signed [W-1:0] w_b,
    input  logic signed [W-1:0] lim_static,
    input  logic signed [W-1:0] lim_rise,
    input  logic signed [W-1:0] lim_fall,
    output xt_pkg::pin_viol_t   bad
);

    // Two terms of magnitude up to 2^(W-1), plus negation headroom.
    localparam int SW = W + 2;

    function automatic logic signed [SW-1:0] ext(input logic signed [W-1:0] v);
        return {{(SW-W){v[W-1]}}, v};
    endfunction

    function automatic logic signed [SW-1:0] term(input trit_e t, input logic signed [W-1:0] w);
        case (t)
            TR_RISE: return ext(w);
            TR_FALL: return -ext(w);
            default: return '0;
        endcase
    endfunction

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] win_hi;
    logic signed [SW-1:0] win_lo;

    always_comb begin
        sum    = term(nb_a, w_a) + term(nb_b, w_b);
        win_hi = ext(lim_static);
        win_lo = -win_hi;
        bad.rise_bad  = (self_t == TR_RISE)  && !(sum > ext(lim_rise));
        bad.fall_bad  = (self_t == TR_FALL)  && !(sum < ext(lim_fall));
        bad.still_bad = (self_t == TR_STILL) && !((sum > win_lo) && (sum < win_hi));
    end

endmodule

// File: rtl/xt_supply_rule.sv
module xt_supply_rule
    import xt_pkg::*;
#(
    parameter int            W     = VAL_W,
    parameter int            N     = SIG_PINS,
    parameter xt_pkg::trit_e WATCH = TR_RISE
) (
    input  xt_pkg::trit_e [N-1:0] codes,
    input  logic signed [W-1:0]   z_step,
    input  logic signed [W-1:0]   lim,
    output logic                  bad
);

    // Room for z_step times N, and for twice the limit.
    localparam int BW = W + $clog2(N + 1) + 1;

    logic signed [BW-1:0] zx;
    logic signed [BW-1:0] acc;
    logic signed [BW-1:0] bound;

    always_comb begin
        zx    = {{(BW-W){z_step[W-1]}}, z_step};
        bound = {{(BW-W){lim[W-1]}}, lim};
        bound = bound + bound;
        acc   = '0;
        for (int i = 0; i < N; i++) begin
            if (codes[i] == WATCH) acc = acc + zx;
        end
        bad = !(acc < bound);
    end

endmodule

// File: rtl/xt_transition_check.sv
module xt_transition_check
    import xt_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  logic [SIG_PINS-1:0] prev_word,
    input  logic [SIG_PINS-1:0] next_word,
    input  logic signed [W-1:0] k_near,
    input  logic signed [W-1:0] k_far,
    input  logic signed [W-1:0] z_step,
    input  logic signed [W-1:0] lim_static,
    input  logic signed [W-1:0] lim_rise,
    input  logic signed [W-1:0] lim_fall,
    input  logic signed [W-1:0] lim_bounce,
    output logic [RULE_CNT-1:0] viol,
    output logic                legal
);

    trit_e [SIG_PINS-1:0] codes;

    xt_trit_enc #(.N(SIG_PINS)) u_enc (
        .old_bits (prev_word),
        .new_bits (next_word),
        .codes    (codes)
    );

    for (genvar g = 0; g < SIG_PINS; g++) begin : g_pin
        localparam int LO   = partner_lo(g);
        localparam int HI   = partner_hi(g);
        localparam int BASE = 1 + RULES_PER_SIG * g;
        pin_viol_t pv;

        xt_pin_rule #(.W(W)) u_rule (
            .self_t     (codes[g]),
            .nb_a       (codes[LO]),
            .nb_b       (codes[HI]),
            .w_a        ((pin_dist(LO, g) == 1) ? k_near : k_far),
            .w_b        ((pin_dist(HI, g) == 1) ? k_near : k_far),
            .lim_static (lim_static),
            .lim_rise   (lim_rise),
            .lim_fall   (lim_fall),
            .bad        (pv)
        );

        assign viol[BASE]     = pv.rise_bad;
        assign viol[BASE + 1] = pv.fall_bad;
        assign viol[BASE + 2] = pv.still_bad;
    end

    xt_supply_rule #(.W(W), .N(SIG_PINS), .WATCH(TR_RISE)) u_vdd (
        .codes  (codes),
        .z_step (z_step),
        .lim    (lim_bounce),
        .bad    (viol[VDD_BIT])
    );

    xt_supply_rule #(.W(W), .N(SIG_PINS), .WATCH(TR_FALL)) u_vss (
        .codes  (codes),
        .z_step (z_step),
        .lim    (lim_bounce),
        .bad    (viol[VSS_BIT])
    );

    assign legal = ~|viol;

endmodule

// File: rtl/xt_transition_check_sva.sv
module xt_transition_check_sva
    import xt_pkg::*;
#(
    parameter int W = VAL_W
) (
    input logic [SIG_PINS-1:0] prev_word,
    input logic [SIG_PINS-1:0] next_word,
    input logic signed [W-1:0] lim_bounce,
    input logic [RULE_CNT-1:0] viol,
    input logic                legal
);

    always_comb begin
        assert_legal_nor_R10: assert (legal == (viol == '0));
        assert_quiet_supply_R6: assert (!((prev_word == next_word) && (lim_bounce > 0)) || !viol[VDD_BIT]);
        assert_quiet_ground_R7: assert (!((prev_word == next_word) && (lim_bounce > 0)) || !viol[VSS_BIT]);
    end

    for (genvar g = 0; g < SIG_PINS; g++) begin : g_pin
        localparam int BASE = 1 + RULES_PER_SIG * g;
        always_comb begin
            assert_one_rule_R9: assert ($onehot0(viol[BASE +: RULES_PER_SIG]));
            assert_rise_gate_R3: assert (!viol[BASE] || (!prev_word[g] && next_word[g]));
            assert_fall_gate_R4: assert (!viol[BASE + 1] || (prev_word[g] && !next_word[g]));
            assert_still_gate_R2: assert (!viol[BASE + 2] || (prev_word[g] == next_word[g]));
        end
    end

endmodule

bind xt_transition_check xt_transition_check_sva #(.W(W)) u_sva (
    .prev_word  (prev_word),
    .next_word  (next_word),
    .lim_bounce (lim_bounce),
    .viol       (viol),
    .legal      (legal)
);

// File: tb/test_xt_transition_check.sv
module test_xt_transition_check;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [2:0]         prev_word, next_word;
    logic signed [7:0]  k_near, k_far, z_step, lim_static, lim_rise, lim_fall, lim_bounce;
    logic [10:0]        viol;
    logic               legal;

    int checks   = 0;
    int failures = 0;

    xt_transition_check i_xt_transition_check (
        .prev_word  (prev_word),
        .next_word  (next_word),
        .k_near     (k_near),
        .k_far      (k_far),
        .z_step     (z_step),
        .lim_static (lim_static),
        .lim_rise   (lim_rise),
        .lim_fall   (lim_fall),
        .lim_bounce (lim_bounce),
        .viol       (viol),
        .legal      (legal)
    );

    // Reference model built from the requirements.
    function automatic int code_of(input logic o, input logic n);
        return int'(n) - int'(o);
    endfunction

    function automatic logic [2:0] pin_ref(input int c, input int s);
        logic [2:0] r;
        r[0] = (c == 1)  && !(s > int'(lim_rise));
        r[1] = (c == -1) && !(s < int'(lim_fall));
        r[2] = (c == 0)  && !((s > -int'(lim_static)) && (s < int'(lim_static)));
        return r;
    endfunction

    function automatic logic [10:0] model();
        logic [10:0] v;
        int c1, c2, c3, s1, s2, s3, nr, nf;
        c1 = code_of(prev_word[0], next_word[0]);
        c2 = code_of(prev_word[1], next_word[1]);
        c3 = code_of(prev_word[2], next_word[2]);
        s1 = int'(k_near) * c2 + int'(k_far)  * c3;
        s2 = int'(k_near) * c1 + int'(k_near) * c3;
        s3 = int'(k_far)  * c1 + int'(k_near) * c2;
        nr = (c1 == 1) + (c2 == 1) + (c3 == 1);
        nf = (c1 == -1) + (c2 == -1) + (c3 == -1);
        v[0]   = !(int'(z_step) * nr < 2 * int'(lim_bounce));
        v[3:1] = pin_ref(c1, s1);
        v[6:4] = pin_ref(c2, s2);
        v[9:7] = pin_ref(c3, s3);
        v[10]  = !(int'(z_step) * nf < 2 * int'(lim_bounce));
        return v;
    endfunction

    function automatic string tag_of(input int b);
        if (b == 0)  return "R6";
        if (b == 10) return "R7";
        case ((b - 1) % 3)
            0:       return "R3";
            1:       return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b prev=%b next=%b", tag, got, exp, prev_word, next_word);
        end
    endtask

    // Settle at the rising edge and sample at the falling edge.
    task automatic sample_full(input string tag);
        logic [10:0] e;
        @(negedge clk);
        e = model();
        check(tag, viol, e);
        check("R10", {10'b0, legal}, {10'b0, (e == '0)});
    endtask

    task automatic sample_bits();
        logic [10:0] e;
        @(negedge clk);
        e = model();
        for (int b = 0; b < 11; b++) check(tag_of(b), {10'b0, viol[b]}, {10'b0, e[b]});
        check("R10", {10'b0, legal}, {10'b0, (e == '0)});
    endtask

    task automatic set_lims(input int kn, input int kf, input int z, input int p0,
                            input int p1, input int pm1, input int pb);
        @(posedge clk);
        k_near = 8'(kn); k_far = 8'(kf); z_step = 8'(z);
        lim_static = 8'(p0); lim_rise = 8'(p1); lim_fall = 8'(pm1); lim_bounce = 8'(pb);
    endtask

    task automatic set_words(input logic [2:0] o, input logic [2:0] n);
        prev_word = o;
        next_word = n;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7391));

        // Initial state: all inputs zero.
        set_words(3'b000, 3'b000);
        set_lims(0, 0, 0, 0, 0, 0, 0);
        sample_full("R10");

        // R1: with zero weights and zero limits each pin trips exactly the rule of its own code.
        set_lims(0, 0, 0, 0, 0, 0, 1);
        set_words(3'b010, 3'b100);
        sample_full("R1");
        @(negedge clk);
        check("R1", viol[9:1], 9'b001_010_100);
        set_words(3'b101, 3'b011);
        sample_full("R1");

        // R6/R7 with R3/R4 in the same cycle: all rising and all falling.
        set_lims(10, 4, 20, 5, 12, -12, 25);
        set_words(3'b000, 3'b111);
        sample_full("R6");
        set_words(3'b111, 3'b000);
        sample_full("R7");
        set_lims(2, 1, 10, 5, 3, -3, 40);
        set_words(3'b000, 3'b111);
        sample_full("R3");
        set_words(3'b111, 3'b000);
        sample_full("R4");

        // R5: near weight much smaller than far weight exposes a swapped weight.
        set_lims(1, 100, 0, 50, 50, -50, 100);
        set_words(3'b000, 3'b011);
        sample_full("R5");
        set_words(3'b000, 3'b101);
        sample_full("R5");
        set_words(3'b110, 3'b010);
        sample_full("R5");

        // R11: extreme values.
        set_lims(-128, -128, -128, -128, 127, -128, -128);
        set_words(3'b000, 3'b111);
        sample_full("R11");
        set_lims(-128, -128, 127, -128, -128, 127, 127);
        set_words(3'b111, 3'b000);
        sample_full("R11");
        set_lims(127, 127, -128, 127, -128, 127, -128);
        set_words(3'b010, 3'b010);
        sample_full("R11");

        // R8/R9: random stimulus, each bit judged at its own position.
        for (int i = 0; i < N_RANDOM; i++) begin
            @(posedge clk);
            prev_word = 3'($urandom);
            next_word = 3'($urandom);
            k_near = 8'($urandom); k_far = 8'($urandom); z_step = 8'($urandom);
            if (i % 2 == 0) begin
                lim_static = 8'($urandom_range(0, 40));
                lim_rise   = 8'(int'($urandom_range(0, 60)) - 30);
                lim_fall   = 8'(int'($urandom_range(0, 60)) - 30);
                lim_bounce = 8'($urandom_range(0, 100));
            end else begin
                lim_static = 8'($urandom); lim_rise = 8'($urandom);
                lim_fall   = 8'($urandom); lim_bounce = 8'($urandom);
            end
            sample_bits();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule